// File: doc/BRIEF.md
# Analog Threshold and Edge Event Report Trigger

This block decides when a remote or router node should send an event report carrying its whole I/O bank. It runs a sample timer, clocked by a 10 ms timebase tick, that strobes the analog converter once per programmed interval. In the strobe cycle it compares three 10-bit conversion results against a low and a high bound each. It also watches four GPIO pins for level changes and accepts a periodic-report tick from outside.

Each analog channel keeps an armed flag, so a channel fires only once when it leaves its window. It cannot fire again until a sample lands back inside the window. An 8-bit enable mask selects which sources may request a report. Sources that fire in the same cycle merge into one single-cycle request. A cause vector shows every enabled source that fired and holds those bits until the host acknowledges. A role input marks a base station, and on a base station the block stays silent.

Top module: `ioReportTrigger`

## Requirements
- R1: `adcReadStb` is a one-cycle pulse. It is raised in the cycle after the N-th `timeTick` counted since the previous strobe, where N is `sampleIntvl`.
- R2: When `sampleIntvl` is 0, the interval defaults to 10 timebase ticks, which is 100 ms.
- R3: A channel is outside its window only when its value is strictly below its low bound or strictly above its high bound. A value equal to either bound counts as inside.
- R4: Every channel is armed after reset. An outside sample on an armed channel fires that channel and disarms it. Further outside samples do nothing. The next inside sample re-arms it.
- R5: A level change on any GPIO, rising or falling, passes through a two-flop synchroniser and fires that GPIO's source. The resulting `reportReq` appears 4 cycles after the pin changes.
- R6: Enable mask and cause bit positions are as follows. Bit 7 is channel 2, bit 6 is channel 1, bit 5 is channel 0, bit 4 is the periodic tick, and bits 3..0 are GPIO3..GPIO0. A one-cycle `periodicTick` gives `reportReq` 2 cycles later.
- R7: Enabled sources that fire in the same cycle produce one single-cycle `reportReq`, and `causeVec` shows all of them. An analog fire gives `reportReq` 2 cycles after the strobe cycle.
- R8: A source whose mask bit is 0 never raises `reportReq` and never sets a `causeVec` bit. Arming still follows the samples while a channel is masked.
- R9: `causeVec` gathers fired sources until `reportAck` is seen. `reportAck` clears the old bits, but a source that fires in the same cycle as `reportAck` is kept.
- R10: While `baseRole` is 1, no `reportReq` is raised and `causeVec` gains no bits.
- R11: In each strobe cycle the synchronised levels of GPIO3 and GPIO2 are captured on `gpioSnap[1:0]`, with GPIO3 in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baseRole | input | 1 | 1 when the node is the base station |
| timeTick | input | 1 | One-cycle pulse every 10 ms |
| sampleIntvl | input | 8 | Sample interval in timebase ticks; 0 selects 10 |
| trigMask | input | 8 | Source enable mask |
| adcVal | input | 30 | Conversion results, channel c in bits 10c+9..10c |
| adcLo | input | 30 | Low bounds, same packing |
| adcHi | input | 30 | High bounds, same packing |
| gpioIn | input | 4 | Asynchronous GPIO levels |
| periodicTick | input | 1 | Periodic report tick |
| reportAck | input | 1 | Clears the cause vector |
| adcReadStb | output | 1 | Converter read strobe; results are compared in this cycle |
| reportReq | output | 1 | One-cycle report request |
| causeVec | output | 8 | Sources that fired since the last acknowledge |
| gpioSnap | output | 2 | GPIO3/GPIO2 levels captured at the last strobe |

## Verification
Each result has a fixed due cycle, counted in clock edges from the stimulus:
- the strobe is due 1 edge after the last `timeTick`;
- an analog report is due 2 edges after the strobe, so 3 after the tick;
- a GPIO report is due 4 edges after the pin change;
- a periodic report is due 2 edges after its tick.

The driver computes this due cycle from a free-running cycle count and queues it together with the expected cause vector. The monitor samples on falling edges and pops the queue. It fails any request whose cycle or cause does not match, any queued item whose cycle passes with no request, and any request that arrives with nothing queued. Quiet cases, such as no re-fire, bound equality, masked sources and base role, are checked by the absence of a request and by the cause vector read after the due cycle.

// File: rtl/ioTrigPkg.sv
package ioTrigPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sample;   // conversion results valid, compare and capture now
  } ctrlStb_t;

endpackage

// File: rtl/ioTrigDatapath.sv
module ioTrigDatapath
  import ioTrigPkg::*;
#(
  parameter int ADC_W  = 10,
  parameter int N_ADC  = 3,
  parameter int N_GPIO = 4,
  localparam int MASK_W = N_ADC + 1 + N_GPIO,
  localparam int VEC_W  = N_ADC * ADC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [VEC_W-1:0]  adcVal,
  input  logic [VEC_W-1:0]  adcLo,
  input  logic [VEC_W-1:0]  adcHi,
  input  logic [N_GPIO-1:0] gpioIn,
  input  logic              periodicTick,
  output logic [MASK_W-1:0] hitVec,
  output logic [1:0]        gpioSnap
);

  logic [N_GPIO-1:0] gSync1, gSync2, gPrev, gpioHit;
  logic [N_ADC-1:0]  adcHit, armed;
  logic              perHit;

  // GPIO synchroniser and change detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gSync1  <= '0;
      gSync2  <= '0;
      gPrev   <= '0;
      gpioHit <= '0;
    end else begin
      gSync1  <= gpioIn;
      gSync2  <= gSync1;
      gPrev   <= gSync2;
      gpioHit <= gSync2 ^ gPrev;
    end
  end

  // Periodic tick and snapshot of GPIO3/GPIO2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perHit   <= 1'b0;
      gpioSnap <= '0;
    end else begin
      perHit <= periodicTick;
      if (stb.sample) gpioSnap <= gSync2[3:2];
    end
  end

  // Per-channel window compare with arm/disarm state
  for (genvar c = 0; c < N_ADC; c++) begin : gChan
    logic [ADC_W-1:0] val, lo, hi;
    logic             outside;

    assign val     = adcVal[c*ADC_W +: ADC_W];
    assign lo      = adcLo[c*ADC_W +: ADC_W];
    assign hi      = adcHi[c*ADC_W +: ADC_W];
    assign outside = (val < lo) || (val > hi);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armed[c]  <= 1'b1;
        adcHit[c] <= 1'b0;
      end else if (stb.sample) begin
        armed[c]  <= !outside;
        adcHit[c] <= outside && armed[c];
      end else begin
        adcHit[c] <= 1'b0;
      end
    end

    // R4: a channel cannot fire on two samples in a row
    a_r4_no_refire: assert property (@(posedge clk) disable iff (!rstN)
      adcHit[c] |=> !adcHit[c]);
  end

  assign hitVec = {adcHit, perHit, gpioHit};

  // R11: snapshot follows the synchronised pins at each sample
  a_r11_snap: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |=> gpioSnap == $past(gSync2[3:2]));

endmodule

// File: rtl/ioTrigCtrl.sv
module ioTrigCtrl
  import ioTrigPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEF_INTVL = 10,
  parameter int MASK_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timeTick,
  input  logic [CNT_W-1:0]  sampleIntvl,
  input  logic [MASK_W-1:0] trigMask,
  input  logic              baseRole,
  input  logic              reportAck,
  input  logic [MASK_W-1:0] hitVec,
  output ctrlStb_t          stb,
  output logic              adcReadStb,
  output logic              reportReq,
  output logic [MASK_W-1:0] causeVec
);

  logic [CNT_W-1:0]  tickCnt, intvlEff;
  logic [CNT_W:0]    nextCnt;
  logic [MASK_W-1:0] fireVec;

  assign intvlEff = (sampleIntvl == '0) ? CNT_W'(DEF_INTVL) : sampleIntvl;
  assign nextCnt  = {1'b0, tickCnt} + {{CNT_W{1'b0}}, 1'b1};

  // Sample interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt    <= '0;
      adcReadStb <= 1'b0;
    end else begin
      adcReadStb <= 1'b0;
      if (timeTick) begin
        if (nextCnt >= {1'b0, intvlEff}) begin
          tickCnt    <= '0;
          adcReadStb <= 1'b1;
        end else begin
          tickCnt <= nextCnt[CNT_W-1:0];
        end
      end
    end
  end

  assign stb.sample = adcReadStb;

  // Report decision and cause latch
  assign fireVec = hitVec & trigMask & {MASK_W{!baseRole}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reportReq <= 1'b0;
      causeVec  <= '0;
    end else begin
      reportReq <= |fireVec;
      causeVec  <= (reportAck ? '0 : causeVec) | fireVec;
    end
  end

  // R1: a strobe always follows a timebase tick
  a_r1_strobe_tick: assert property (@(posedge clk) disable iff (!rstN)
    adcReadStb |-> $past(timeTick));
  // R10: base station stays silent
  a_r10_base_quiet: assert property (@(posedge clk) disable iff (!rstN)
    baseRole |=> !reportReq);
  // R7: a request always carries at least one cause
  a_r7_req_cause: assert property (@(posedge clk) disable iff (!rstN)
    reportReq |-> causeVec != '0);
  // R9: after acknowledge only same-cycle hits remain
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    reportAck |=> (causeVec & ~$past(hitVec)) == '0);

endmodule

// File: rtl/ioReportTrigger.sv
module ioReportTrigger
  import ioTrigPkg::*;
#(
  parameter int ADC_W     = 10,
  parameter int N_ADC     = 3,
  parameter int N_GPIO    = 4,
  parameter int CNT_W     = 8,
  parameter int DEF_INTVL = 10,
  localparam int MASK_W   = N_ADC + 1 + N_GPIO,
  localparam int VEC_W    = N_ADC * ADC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseRole,
  input  logic              timeTick,
  input  logic [CNT_W-1:0]  sampleIntvl,
  input  logic [MASK_W-1:0] trigMask,
  input  logic [VEC_W-1:0]  adcVal,
  input  logic [VEC_W-1:0]  adcLo,
  input  logic [VEC_W-1:0]  adcHi,
  input  logic [N_GPIO-1:0] gpioIn,
  input  logic              periodicTick,
  input  logic              reportAck,
  output logic              adcReadStb,
  output logic              reportReq,
  output logic [MASK_W-1:0] causeVec,
  output logic [1:0]        gpioSnap
);

  ctrlStb_t          stb;
  logic [MASK_W-1:0] hitVec;

  ioTrigCtrl #(
    .CNT_W(CNT_W), .DEF_INTVL(DEF_INTVL), .MASK_W(MASK_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .timeTick(timeTick), .sampleIntvl(sampleIntvl),
    .trigMask(trigMask), .baseRole(baseRole), .reportAck(reportAck),
    .hitVec(hitVec), .stb(stb), .adcReadStb(adcReadStb),
    .reportReq(reportReq), .causeVec(causeVec)
  );

  ioTrigDatapath #(
    .ADC_W(ADC_W), .N_ADC(N_ADC), .N_GPIO(N_GPIO)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .adcVal(adcVal), .adcLo(adcLo),
    .adcHi(adcHi), .gpioIn(gpioIn), .periodicTick(periodicTick),
    .hitVec(hitVec), .gpioSnap(gpioSnap)
  );

endmodule

// File: tb/tb_ioReportTrigger.sv
module tb_ioReportTrigger;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseRole = 1'b0;
  logic        timeTick = 1'b0;
  logic [7:0]  sampleIntvl = 8'd1;
  logic [7:0]  trigMask = 8'hFF;
  logic [29:0] adcVal = {10'd500, 10'd500, 10'd500};
  logic [29:0] adcLo  = {10'd100, 10'd100, 10'd100};
  logic [29:0] adcHi  = {10'd900, 10'd900, 10'd900};
  logic [3:0]  gpioIn = 4'h0;
  logic        periodicTick = 1'b0;
  logic        reportAck = 1'b0;
  logic        adcReadStb, reportReq;
  logic [7:0]  causeVec;
  logic [1:0]  gpioSnap;

  always #5 clk = ~clk;

  ioReportTrigger dut (
    .clk(clk), .rstN(rstN), .baseRole(baseRole), .timeTick(timeTick),
    .sampleIntvl(sampleIntvl), .trigMask(trigMask), .adcVal(adcVal),
    .adcLo(adcLo), .adcHi(adcHi), .gpioIn(gpioIn),
    .periodicTick(periodicTick), .reportAck(reportAck),
    .adcReadStb(adcReadStb), .reportReq(reportReq), .causeVec(causeVec),
    .gpioSnap(gpioSnap)
  );

  int cyc = 0;
  int total = 0;
  int bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    logic [7:0] cause;
    string      req;
  } expItem_t;
  expItem_t sbQ[$];
  expItem_t got;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: pop scoreboard items as requests appear
  always @(negedge clk) begin
    if (rstN) begin
      if (reportReq) begin
        if (sbQ.size() == 0 || sbQ[0].due != cyc) begin
          check(1'b0, "R7", "unexpected request at cycle", cyc,
                (sbQ.size() > 0) ? sbQ[0].due : -1);
        end else begin
          got = sbQ.pop_front();
          check(causeVec == got.cause, got.req, "cause vector",
                int'(causeVec), int'(got.cause));
        end
      end else if (sbQ.size() > 0 && sbQ[0].due <= cyc) begin
        got = sbQ.pop_front();
        check(1'b0, got.req, "missing request, due cycle", cyc, got.due);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doAck();
    reportAck = 1'b1;
    step(1);
    reportAck = 1'b0;
    check(causeVec == 8'h00, "R9", "cause after ack", int'(causeVec), 0);
  endtask

  task automatic adcSample(input logic [9:0] v0, input logic [9:0] v1,
                           input logic [9:0] v2, input logic [7:0] expCause,
                           input string req);
    adcVal = {v2, v1, v0};
    timeTick = 1'b1;
    if (expCause != 8'h00) sbQ.push_back('{cyc + 3, expCause, req});
    step(1);
    timeTick = 1'b0;
    step(5);
    check(causeVec == expCause, req, "cause after sample",
          int'(causeVec), int'(expCause));
    if (expCause != 8'h00) doAck();
  endtask

  task automatic gpioFlip(input int idx, input logic [7:0] expCause,
                          input string req);
    gpioIn[idx] = ~gpioIn[idx];
    if (expCause != 8'h00) sbQ.push_back('{cyc + 4, expCause, req});
    step(7);
    check(causeVec == expCause, req, "cause after gpio change",
          int'(causeVec), int'(expCause));
    if (expCause != 8'h00) doAck();
  endtask

  task automatic strobeGap(input string req, input int expGap);
    int t0;
    do step(1); while (!adcReadStb);
    t0 = cyc;
    step(1);
    check(!adcReadStb, req, "strobe width above one cycle", 1, 0);
    while (!adcReadStb) step(1);
    check(cyc - t0 == expGap, req, "strobe spacing", cyc - t0, expGap);
  endtask

  initial begin
    step(3);
    check(reportReq == 1'b0 && causeVec == 8'h00 && adcReadStb == 1'b0,
          "R4", "reset outputs", int'({reportReq, adcReadStb, causeVec}), 0);
    rstN = 1'b1;
    step(2);

    // R2 default interval, R1 programmed interval
    sampleIntvl = 8'd0;
    timeTick = 1'b1;
    strobeGap("R2", 10);
    sampleIntvl = 8'd3;
    step(1);
    strobeGap("R1", 3);
    timeTick = 1'b0;
    sampleIntvl = 8'd1;
    step(3);

    // R3 and R4: window compare and arming
    adcSample(10'd50,  10'd500, 10'd500, 8'h20, "R4");
    adcSample(10'd40,  10'd500, 10'd500, 8'h00, "R4");
    adcSample(10'd100, 10'd500, 10'd500, 8'h00, "R3");
    adcSample(10'd901, 10'd500, 10'd500, 8'h20, "R3");
    adcSample(10'd900, 10'd500, 10'd500, 8'h00, "R3");
    adcSample(10'd99,  10'd500, 10'd500, 8'h20, "R4");
    // R7: two channels in one sample merge into one request
    adcSample(10'd500, 10'd1023, 10'd0, 8'hC0, "R7");
    // R8: masked channel fires nothing, arming still tracks
    adcSample(10'd500, 10'd500, 10'd500, 8'h00, "R4");
    trigMask = 8'hDF;
    adcSample(10'd20,  10'd500, 10'd500, 8'h00, "R8");
    trigMask = 8'hFF;
    adcSample(10'd20,  10'd500, 10'd500, 8'h00, "R8");
    adcSample(10'd500, 10'd500, 10'd500, 8'h00, "R4");

    // R5: both edge directions, R6 bit positions
    gpioFlip(1, 8'h02, "R5");
    gpioFlip(1, 8'h02, "R5");
    gpioFlip(3, 8'h08, "R6");
    gpioFlip(3, 8'h08, "R6");
    trigMask = 8'hFE;
    gpioFlip(0, 8'h00, "R8");
    trigMask = 8'hFF;

    // R6: periodic tick
    periodicTick = 1'b1;
    sbQ.push_back('{cyc + 2, 8'h10, "R6"});
    step(1);
    periodicTick = 1'b0;
    step(4);
    check(causeVec == 8'h10, "R6", "periodic cause", int'(causeVec), 16);

    // R9: accumulate without ack, then ack in the cycle of a new hit
    gpioFlip(0, 8'h11, "R9");
    periodicTick = 1'b1;
    sbQ.push_back('{cyc + 2, 8'h10, "R9"});
    step(1);
    periodicTick = 1'b0;
    reportAck = 1'b1;
    step(1);
    reportAck = 1'b0;
    step(3);
    check(causeVec == 8'h10, "R9", "hit kept over same-cycle ack",
          int'(causeVec), 16);
    doAck();

    // R10: base role silences all sources
    baseRole = 1'b1;
    periodicTick = 1'b1;
    step(1);
    periodicTick = 1'b0;
    step(4);
    check(causeVec == 8'h00, "R10", "cause under base role",
          int'(causeVec), 0);
    gpioFlip(2, 8'h00, "R10");
    baseRole = 1'b0;
    step(2);

    // R11: snapshot of GPIO3/GPIO2 at the strobe
    trigMask = 8'h00;
    gpioIn[3] = 1'b1;
    gpioIn[2] = 1'b0;
    step(6);
    adcSample(10'd500, 10'd500, 10'd500, 8'h00, "R11");
    check(gpioSnap == 2'b10, "R11", "gpio snapshot", int'(gpioSnap), 2);
    gpioIn[3] = 1'b0;
    gpioIn[2] = 1'b1;
    step(6);
    adcSample(10'd500, 10'd500, 10'd500, 8'h00, "R11");
    check(gpioSnap == 2'b01, "R11", "gpio snapshot", int'(gpioSnap), 1);
    trigMask = 8'hFF;

    step(6);
    check(sbQ.size() == 0, "R7", "scoreboard left over", sbQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule